// File: doc/BRIEF.md
# Serial Receive Engine with Two-Deep Status Queue

This block turns an asynchronous serial line into received characters. The line first passes through a two-flop synchronizer. Reception starts on a falling edge that is still low at the middle of the start bit. The engine then samples between five and nine data bits, least significant bit first, and an optional parity bit. It checks only the first stop bit. Timing comes from an oversampling strobe at sixteen times the bit rate, supplied from outside. Each data bit is decided by a majority vote of three samples taken around the middle of the bit.

A finished character moves into a two-entry queue. Its ninth bit and its framing, parity and overrun flags travel in the same entry. The status outputs therefore always describe the character at the head of the queue, and they must be read before that character is popped. The queue output is a valid/ready stream. `rx_valid` is the receive-complete flag. A cycle with both `rx_valid` and `rx_ready` high pops the head.

Back-pressure is absorbed by a one-character holding stage behind the queue. When the queue is full, a finished character waits there. If a new start bit is confirmed while that character is still waiting, the waiting character is discarded, and the next character stored carries the overrun flag. A level interrupt request follows the receive-complete flag while its enable is set. Dropping the receive enable empties the queue and stops reception.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, `rx_valid` and `rx_irq` are 0. A low pulse on `rxd` that is no longer low at the middle of the start bit (8 strobes after the edge) is rejected and produces no character.
- R2: Data bits are taken LSB first. Each bit is the majority of three consecutive strobe samples centred on the bit middle, so a low or high glitch one strobe wide inside a bit does not change the received value.
- R3: `cfg_nbits` (valid values 5 to 9) sets the number of data bits. Bits above the configured length read as 0 on `rx_data`. In 9-bit mode the ninth bit appears on `rx_bit9`, which is 0 for shorter frames.
- R4: With `cfg_par_en`=1, one parity bit follows the data. It is even parity when `cfg_par_odd`=0 and odd when it is 1. `rx_perr` is 1 when the received parity bit mismatches. With `cfg_par_en`=0, `rx_perr` is always 0.
- R5: `rx_ferr` is 1 when the first stop bit is sampled as 0. Any further stop bits are not examined, so frames with one or two high stop bits are received identically.
- R6: The queue holds two characters in arrival order. `rx_valid` is high while unread characters exist. A pop exposes the next entry's data and status together.
- R7: A third character that finishes while the queue is full waits in the holding stage. It enters the queue without loss once a slot frees, provided no new start bit arrives first.
- R8: If a start bit is confirmed while the queue is full and a finished character waits in the holding stage, that character is discarded. The next character entering the queue has `rx_ovr`=1, and later characters have `rx_ovr`=0.
- R9: `rx_irq` is 1 exactly when `rx_valid` and `irq_en` are both 1.
- R10: While `rx_en` is 0, the queue is empty one cycle after, `rx_valid` stays 0, and line activity produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; 0 flushes and idles |
| os_tick | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_nbits | input | 4 | Data bits per character, 5 to 9 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| irq_en | input | 1 | Interrupt enable |
| rx_valid | output | 1 | Receive complete: queue not empty |
| rx_ready | input | 1 | Pop the head when rx_valid is high |
| rx_data | output | 8 | Head character, low eight bits |
| rx_bit9 | output | 1 | Head character, ninth bit |
| rx_ferr | output | 1 | Head framing error |
| rx_perr | output | 1 | Head parity error |
| rx_ovr | output | 1 | Head overrun marker |
| rx_irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `cfg_nbits`, `cfg_par_en` and `cfg_par_odd` stay constant while a character is being received or waits in the holding stage, and that `cfg_nbits` stays within 5 to 9. The bench changes configuration only with the line idle and the queue drained. `os_tick` is assumed to be a single-cycle strobe spaced several clocks apart. The bench generates it every fourth clock and drives every bit for exactly sixteen strobes, so sampling points never fall near a bit edge, except for deliberate one-strobe glitches.

// File: rtl/srx_pkg.sv
package srx_pkg;
  parameter int MAX_BITS = 9;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                fe;
    logic                pe;
    logic                dor;
  } srx_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } srx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [3:0] cfg_nbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       out_valid,
  input  logic       out_ready,
  output srx_entry_t out_entry
);
  localparam int CW = $clog2(OVS);
  localparam int MID = OVS/2 - 1;
  localparam logic [CW-1:0] C_V0   = CW'(MID - 1);
  localparam logic [CW-1:0] C_V1   = CW'(MID);
  localparam logic [CW-1:0] C_V2   = CW'(MID + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);

  srx_state_t          st;
  logic [CW-1:0]       cnt;
  logic [3:0]          idx;
  logic [MAX_BITS-1:0] shreg;
  logic                par_rx;
  logic                v0, v1;
  logic                prev;
  srx_entry_t          hold;
  logic                hold_v;
  logic                ovr;

  logic       vote;
  logic [3:0] last_idx;
  logic       exp_par;
  logic       stop_fire;
  logic       start_ok;

  assign vote      = (v0 & v1) | (v0 & rxd_s) | (v1 & rxd_s);
  assign last_idx  = cfg_nbits + {3'b000, cfg_par_en} - 4'd1;
  assign exp_par   = (^shreg) ^ cfg_par_odd;
  assign stop_fire = en && tick && (st == ST_STOP) && (cnt == C_V2);
  assign start_ok  = en && tick && (st == ST_START) && (cnt == C_V1) && !rxd_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      par_rx <= 1'b0;
      v0     <= 1'b0;
      v1     <= 1'b0;
      prev   <= 1'b0;
      hold   <= '0;
      hold_v <= 1'b0;
      ovr    <= 1'b0;
    end else if (!en) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      hold_v <= 1'b0;
      ovr    <= 1'b0;
      prev   <= rxd_s;
    end else begin
      if (hold_v && out_ready) begin
        hold_v <= 1'b0;
        ovr    <= 1'b0;
      end
      if (tick) begin
        if (st != ST_IDLE) cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
        if (cnt == C_V0) v0 <= rxd_s;
        if (cnt == C_V1) v1 <= rxd_s;
        unique case (st)
          ST_IDLE: begin
            prev <= rxd_s;
            if (prev && !rxd_s) begin
              st    <= ST_START;
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
            end
          end
          ST_START: begin
            if (cnt == C_V1 && rxd_s) begin
              st   <= ST_IDLE;
              prev <= 1'b1;
            end else if (start_ok && hold_v && !out_ready) begin
              hold_v <= 1'b0;
              ovr    <= 1'b1;
            end
            if (cnt == C_LAST) st <= ST_BITS;
          end
          ST_BITS: begin
            if (cnt == C_V2) begin
              if (idx < cfg_nbits) shreg[idx] <= vote;
              else par_rx <= vote;
            end
            if (cnt == C_LAST) begin
              if (idx == last_idx) st <= ST_STOP;
              else idx <= idx + 4'd1;
            end
          end
          ST_STOP: begin
            if (cnt == C_V2) begin
              hold.data <= shreg;
              hold.fe   <= ~vote;
              hold.pe   <= cfg_par_en && (par_rx != exp_par);
              hold.dor  <= ovr;
              hold_v    <= 1'b1;
              st        <= ST_IDLE;
              cnt       <= '0;
              prev      <= rxd_s;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign out_valid = hold_v;
  assign out_entry = hold;

  assert_pe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_fire && !cfg_par_en) |=> (hold_v && !hold.pe));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> ((hold.data >> cfg_nbits) == '0));

  assert_drop_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> !hold_v);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       in_valid,
  output logic       in_ready,
  input  srx_entry_t in_entry,
  output logic       out_valid,
  input  logic       out_ready,
  output srx_entry_t out_entry
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] P_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   C_FULL = (AW+1)'(DEPTH);

  srx_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [AW:0]   count;
  logic          push, pop;

  assign in_ready  = (count != C_FULL);
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_entry = mem[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wr_p] <= in_entry;
        wr_p      <= (wr_p == P_LAST) ? '0 : wr_p + 1'b1;
      end
      if (pop) rd_p <= (rd_p == P_LAST) ? '0 : rd_p + 1'b1;
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= C_FULL);

  assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_entry)));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [3:0] cfg_nbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       irq_en,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_ferr,
  output logic       rx_perr,
  output logic       rx_ovr,
  output logic       rx_irq
);
  logic       rxd_s;
  logic       f_valid, f_ready;
  srx_entry_t f_entry, head;

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  srx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rxd_s(rxd_s),
    .cfg_nbits(cfg_nbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .out_valid(f_valid), .out_ready(f_ready), .out_entry(f_entry)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en),
    .in_valid(f_valid), .in_ready(f_ready), .in_entry(f_entry),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_entry(head)
  );

  assign rx_data = head.data[7:0];
  assign rx_bit9 = head.data[8];
  assign rx_ferr = head.fe;
  assign rx_perr = head.pe;
  assign rx_ovr  = head.dor;
  assign rx_irq  = rx_valid && irq_en;

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_valid);
endmodule

// File: tb/sim_serial_rx_engine.sv
module sim_serial_rx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BIT_CLK    = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [3:0] cfg_nbits = 4'd8;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       irq_en = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid, rx_bit9, rx_ferr, rx_perr, rx_ovr, rx_irq;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  serial_rx_engine u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
    .cfg_nbits(cfg_nbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .irq_en(irq_en), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr),
    .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV-1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    if (glitch) begin
      rxd = v;  repeat (BIT_CLK/2 - 2) @(negedge clk);
      rxd = ~v; repeat (TDIV) @(negedge clk);
      rxd = v;  repeat (BIT_CLK/2 - 2) @(negedge clk);
    end else begin
      rxd = v;
      repeat (BIT_CLK) @(negedge clk);
    end
  endtask

  task automatic send(input int val, input int nb, input bit pen, input bit podd,
                      input bit stopv, input int nstop, input bit badpar, input int gbit);
    bit p;
    p = podd;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) begin
      drive_bit(val[i], gbit == i);
      p ^= val[i];
    end
    if (pen) drive_bit(p ^ badpar, 1'b0);
    drive_bit(stopv, 1'b0);
    for (int i = 1; i < nstop; i++) drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic take(input string req, input int d, input int b9, input int fe,
                      input int pe, input int dor);
    chk({req, " valid"}, rx_valid, 1);
    chk({req, " data"}, rx_data, d);
    chk({req, " bit9"}, rx_bit9, b9);
    chk({req, " ferr"}, rx_ferr, fe);
    chk({req, " perr"}, rx_perr, pe);
    chk({req, " ovr"}, rx_ovr, dor);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", rx_valid, 0);
    chk("R1 reset irq", rx_irq, 0);
  endtask

  task automatic t_noise;
    rxd = 1'b0; repeat (3*TDIV) @(negedge clk);
    rxd = 1'b1; repeat (2*BIT_CLK*12) @(negedge clk);
    chk("R1 short pulse rejected", rx_valid, 0);
  endtask

  task automatic t_basic;
    send(8'hA5, 8, 0, 0, 1, 1, 0, -1);
    take("R2 basic 0xA5", 8'hA5, 0, 0, 0, 0);
    send(8'h3C, 8, 0, 0, 1, 1, 0, 2);
    take("R2 glitch bit2", 8'h3C, 0, 0, 0, 0);
    send(8'h01, 8, 0, 0, 1, 1, 0, 0);
    take("R2 glitch bit0", 8'h01, 0, 0, 0, 0);
  endtask

  task automatic t_length;
    cfg_nbits = 4'd5;
    send(8'hF5, 5, 0, 0, 1, 1, 0, -1);
    take("R3 five bits upper zero", 8'h15, 0, 0, 0, 0);
    cfg_nbits = 4'd9;
    send(9'h1A5, 9, 0, 0, 1, 1, 0, -1);
    take("R3 nine bits", 8'hA5, 1, 0, 0, 0);
    send(9'h05A, 9, 0, 0, 1, 1, 0, -1);
    take("R3 nine bits bit9 low", 8'h5A, 0, 0, 0, 0);
    cfg_nbits = 4'd8;
  endtask

  task automatic t_parity;
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h37, 8, 1, 0, 1, 1, 0, -1);
    take("R4 even good", 8'h37, 0, 0, 0, 0);
    send(8'h37, 8, 1, 0, 1, 1, 1, -1);
    take("R4 even bad", 8'h37, 0, 0, 1, 0);
    cfg_par_odd = 1'b1;
    send(8'h80, 8, 1, 1, 1, 1, 0, -1);
    take("R4 odd good", 8'h80, 0, 0, 0, 0);
    send(8'h80, 8, 1, 1, 1, 1, 1, -1);
    take("R4 odd bad", 8'h80, 0, 0, 1, 0);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    send(8'h81, 8, 1, 0, 1, 1, 1, -1);
    chk("R4 parity off extra bit as stop", rx_valid, 1);
    chk("R4 parity off perr", rx_perr, 0);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    repeat (BIT_CLK*12) @(negedge clk);
    while (rx_valid) begin rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk); end
  endtask

  task automatic t_stop;
    send(8'h55, 8, 0, 0, 0, 1, 0, -1);
    take("R5 bad stop", 8'h55, 0, 1, 0, 0);
    send(8'h66, 8, 0, 0, 1, 2, 0, -1);
    take("R5 two stops", 8'h66, 0, 0, 0, 0);
  endtask

  task automatic t_queue;
    irq_en = 1'b1;
    send(8'h11, 8, 0, 0, 1, 1, 0, -1);
    chk("R9 irq with data", rx_irq, 1);
    irq_en = 1'b0; @(negedge clk);
    chk("R9 irq masked", rx_irq, 0);
    irq_en = 1'b1;
    send(8'h22, 8, 0, 0, 1, 1, 0, -1);
    send(8'h33, 8, 0, 0, 1, 1, 0, -1);
    take("R6 first", 8'h11, 0, 0, 0, 0);
    take("R6 second", 8'h22, 0, 0, 0, 0);
    take("R7 held third", 8'h33, 0, 0, 0, 0);
    chk("R6 empty after drain", rx_valid, 0);
    chk("R9 irq drops", rx_irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_overrun;
    send(8'hA1, 8, 0, 0, 1, 1, 0, -1);
    send(8'hB2, 8, 0, 0, 1, 1, 0, -1);
    send(8'hC3, 8, 0, 0, 1, 1, 0, -1);
    send(8'hD4, 8, 0, 0, 1, 1, 0, -1);
    take("R8 first kept", 8'hA1, 0, 0, 0, 0);
    take("R8 second kept", 8'hB2, 0, 0, 0, 0);
    take("R8 flagged after loss", 8'hD4, 0, 0, 0, 1);
    chk("R8 held frame dropped", rx_valid, 0);
    send(8'hE5, 8, 0, 0, 1, 1, 0, -1);
    take("R8 flag cleared", 8'hE5, 0, 0, 0, 0);
  endtask

  task automatic t_disable;
    send(8'h12, 8, 0, 0, 1, 1, 0, -1);
    send(8'h34, 8, 0, 0, 1, 1, 0, -1);
    chk("R10 data before disable", rx_valid, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R10 flushed", rx_valid, 0);
    send(8'h56, 8, 0, 0, 1, 1, 0, -1);
    chk("R10 ignored while off", rx_valid, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 still empty on enable", rx_valid, 0);
    send(8'h78, 8, 0, 0, 1, 1, 0, -1);
    take("R10 resumes", 8'h78, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
    t_noise();
    t_basic();
    t_length();
    t_parity();
    t_stop();
    t_queue();
    t_overrun();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule